// File: doc/BRIEF.md
# Context-Tagged Memory Region Guard

This block sits on the request path between bus initiators and main memory. Each request carries a 4-bit execution-context tag. The tag tells the block whether the request comes from the security monitor, the platform firmware, the operating system or one of thirteen isolated enclaves. The block compares the request address with fifteen region descriptors. Each descriptor holds a base, a mask and a valid bit. The rule that applies depends on the context class. A request that is permitted goes to memory unchanged, one cycle later.

A request that is forbidden is not faulted. The block steers it to a fixed scratch address that always holds zeros, and it forces the write data to zero. A forbidden read therefore returns zeros, and a forbidden write cannot change protected memory. A forbidden request also sets a sticky interrupt. The context and address of the first offending request since the last clear are kept for the monitor to read.

Region descriptors are loaded through a narrow write port. Only the monitor context may use that port, and writes that carry any other tag are dropped.

Top module: `mem_region_guard`

## Requirements
- R1: Region i matches an address A when its valid bit is 1 and (A & mask_i) == (base_i & mask_i). Any mask pattern is allowed, including masks that are not contiguous.
- R2: A request tagged 4'hF (monitor) is always permitted, whatever address it carries.
- R3: A request tagged 1..13 (enclave) is permitted only if it matches region index (tag-1). If that region is invalid, every request from that enclave is refused.
- R4: A request tagged 4'h0 (OS) is permitted only when its address matches no valid region among all fifteen.
- R5: A request tagged 4'hE (firmware) is permitted when it matches region 14. It is also permitted when it matches no valid region at all.
- R6: out_valid equals req_valid one cycle later. A permitted request appears on the output one cycle later with the same address, write data and write flag.
- R7: A refused request appears one cycle later with out_addr equal to SCRATCH_ADDR and out_wdata equal to zero. Its write flag is kept.
- R8: viol_irq rises in the cycle after a refused request and then stays at 1. It returns to 0 only after a monitor write to cfg_addr 6'h3C. If a refusal and a clear happen in the same cycle, the interrupt stays set. Idle cycles never set it.
- R9: viol_ctx and viol_addr hold the tag and address of the first refused request since the last clear. If a refusal and a clear happen in the same cycle, that refusal is captured.
- R10: The write port maps region r (0..14) at cfg_addr = 4*r + field. Field 0 is the base, field 1 is the mask, and field 2 is the valid bit (wdata bit 0). Region indexes 0..12 belong to enclaves 1..13, index 13 to the monitor and index 14 to the firmware. A write takes effect for requests issued in the following cycle. Writes whose cfg_ctx is not 4'hF change nothing.
- R11: After reset, every region is invalid, viol_irq, viol_ctx and viol_addr are 0, and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | 4 | Context tag of the configuration writer |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Incoming request valid |
| req_ctx | input | 4 | Context tag of the request |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Request write data |
| req_write | input | 1 | 1 for write, 0 for read |
| out_valid | output | 1 | Outgoing request valid |
| out_addr | output | 32 | Outgoing address (scratch address on refusal) |
| out_wdata | output | 32 | Outgoing write data (zero on refusal) |
| out_write | output | 1 | Outgoing write flag |
| viol_irq | output | 1 | Sticky violation interrupt |
| viol_ctx | output | 4 | Tag of the first refused request |
| viol_addr | output | 32 | Address of the first refused request |

## Verification
Three results are due one clock edge after the stimulus that causes them: the forwarded or redirected request, the rise of the interrupt, and the captured status. A region update written through the configuration port affects only requests issued in a later cycle. Inputs are driven after the falling edge. The reference model works out the next state from the inputs and its own state before the rising edge, and every output is compared with that result after the following falling edge. Same-cycle cases, such as a region write together with a request or a clear together with a refusal, are therefore resolved exactly as the requirements state.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  localparam int ID_W   = 4;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int N_ENCL = 13;
  localparam int N_RGN  = N_ENCL + 2;
  localparam int MON_IDX = N_ENCL;
  localparam int FW_IDX  = N_ENCL + 1;
  localparam int CFG_AW  = 6;
  localparam int SEL_W   = CFG_AW - 2;

  localparam logic [ID_W-1:0]   ID_OS  = 4'h0;
  localparam logic [ID_W-1:0]   ID_FW  = 4'hE;
  localparam logic [ID_W-1:0]   ID_MON = 4'hF;
  localparam logic [CFG_AW-1:0] CLR_ADDR = 6'h3C;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
  } rgn_t;

  typedef enum logic [1:0] {CLS_OS, CLS_ENCL, CLS_FW, CLS_MON} cls_e;

  function automatic logic rgn_hit(rgn_t r, logic [ADDR_W-1:0] a);
    return r.vld && ((a & r.mask) == (r.base & r.mask));
  endfunction

  function automatic cls_e ctx_class(logic [ID_W-1:0] c);
    if (c == ID_MON)     return CLS_MON;
    else if (c == ID_FW) return CLS_FW;
    else if (c == ID_OS) return CLS_OS;
    else                 return CLS_ENCL;
  endfunction
endpackage

// File: rtl/mrg_regfile.sv
module mrg_regfile
  import mrg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ID_W-1:0]          cfg_ctx,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output rgn_t [N_RGN-1:0]         rgns,
  output logic                     clr_pulse
);
  logic             cfg_ok;
  logic [SEL_W-1:0] sel;
  logic [1:0]       fld;

  assign cfg_ok    = cfg_we && (cfg_ctx == ID_MON);
  assign sel       = cfg_addr[CFG_AW-1:2];
  assign fld       = cfg_addr[1:0];
  assign clr_pulse = cfg_ok && (cfg_addr == CLR_ADDR);

  for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
    rgn_t r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (cfg_ok && (sel == SEL_W'(g))) begin
        case (fld)
          2'd0:    r_q.base <= cfg_wdata;
          2'd1:    r_q.mask <= cfg_wdata;
          2'd2:    r_q.vld  <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
    assign rgns[g] = r_q;
  end

  // R10
  foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_ctx != ID_MON)) |=> $stable(rgns));
endmodule

// File: rtl/mrg_match.sv
module mrg_match
  import mrg_pkg::*;
(
  input  rgn_t [N_RGN-1:0]  rgns,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_RGN-1:0]  hit
);
  for (genvar g = 0; g < N_RGN; g++) begin : g_hit
    assign hit[g] = rgn_hit(rgns[g], addr);
  end
endmodule

// File: rtl/mrg_policy.sv
module mrg_policy
  import mrg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 32'hFFFF_F000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic [N_RGN-1:0]  hit,
  output logic              viol,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_wdata,
  output logic              out_write
);
  cls_e             cls;
  logic             allow;
  logic             viol_q;
  logic [ID_W-1:0]  enc_idx;

  assign cls     = ctx_class(req_ctx);
  assign enc_idx = req_ctx - 1'b1;

  always_comb begin
    unique case (cls)
      CLS_MON:  allow = 1'b1;
      CLS_ENCL: allow = hit[enc_idx];
      CLS_FW:   allow = hit[FW_IDX] || !(|hit);
      default:  allow = !(|hit);
    endcase
  end

  assign viol = req_valid && !allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_wdata <= '0;
      out_write <= 1'b0;
      viol_q    <= 1'b0;
    end else begin
      out_valid <= req_valid;
      out_write <= req_write;
      viol_q    <= viol;
      out_addr  <= viol ? SCRATCH_ADDR : req_addr;
      out_wdata <= viol ? '0 : req_wdata;
    end
  end

  // R2
  monitor_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ctx == ID_MON) |=>
      (out_valid && out_addr == $past(req_addr) && out_wdata == $past(req_wdata)));
  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R7
  redirect_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> (out_addr == SCRATCH_ADDR && out_wdata == '0));
endmodule

// File: rtl/mrg_irq.sv
module mrg_irq
  import mrg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol,
  input  logic              clr,
  input  logic [ID_W-1:0]   req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              viol_irq,
  output logic [ID_W-1:0]   viol_ctx,
  output logic [ADDR_W-1:0] viol_addr
);
  logic capture;
  assign capture = viol && (!viol_irq || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_irq  <= 1'b0;
      viol_ctx  <= '0;
      viol_addr <= '0;
    end else begin
      if (viol)     viol_irq <= 1'b1;
      else if (clr) viol_irq <= 1'b0;
      if (capture) begin
        viol_ctx  <= req_ctx;
        viol_addr <= req_addr;
      end
    end
  end

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_irq && !clr) |=> viol_irq);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_irq) |-> $past(viol));
  // R9
  status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_irq && !clr) |=> ($stable(viol_ctx) && $stable(viol_addr)));
endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
  import mrg_pkg::*;
#(
  parameter logic [31:0] SCRATCH_ADDR = 32'hFFFF_F000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_ctx,
  input  logic [5:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  input  logic [3:0]  req_ctx,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic        req_write,
  output logic        out_valid,
  output logic [31:0] out_addr,
  output logic [31:0] out_wdata,
  output logic        out_write,
  output logic        viol_irq,
  output logic [3:0]  viol_ctx,
  output logic [31:0] viol_addr
);
  rgn_t [N_RGN-1:0] rgns;
  logic [N_RGN-1:0] hit;
  logic             clr_pulse;
  logic             viol;

  mrg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctx(cfg_ctx),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rgns(rgns), .clr_pulse(clr_pulse)
  );

  mrg_match u_match (.rgns(rgns), .addr(req_addr), .hit(hit));

  mrg_policy #(.SCRATCH_ADDR(SCRATCH_ADDR)) u_policy (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write), .hit(hit),
    .viol(viol), .out_valid(out_valid), .out_addr(out_addr),
    .out_wdata(out_wdata), .out_write(out_write)
  );

  mrg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .viol(viol), .clr(clr_pulse), .req_ctx(req_ctx),
    .req_addr(req_addr), .viol_irq(viol_irq), .viol_ctx(viol_ctx), .viol_addr(viol_addr)
  );
endmodule

// File: tb/mem_region_guard_test.sv
module mem_region_guard_test;
  localparam logic [31:0] SCR = 32'hFFFF_F000;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [3:0] cfg_ctx = 0; logic [5:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic req_valid = 0; logic [3:0] req_ctx = 0; logic [31:0] req_addr = 0, req_wdata = 0; logic req_write = 0;
  logic out_valid, out_write, viol_irq; logic [31:0] out_addr, out_wdata, viol_addr; logic [3:0] viol_ctx;

  mem_region_guard #(.SCRATCH_ADDR(SCR)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur = "R11";

  logic [31:0] m_base [15];
  logic [31:0] m_mask [15];
  bit          m_vld  [15];
  bit m_irq; logic [3:0] m_vctx; logic [31:0] m_vaddr;
  bit e_valid, e_write; logic [31:0] e_addr, e_wdata;

  function automatic bit inside_rgn(int i, logic [31:0] a);
    return m_vld[i] && (((a ^ m_base[i]) & m_mask[i]) == 32'h0);
  endfunction

  function automatic bit permitted(logic [3:0] c, logic [31:0] a);
    if (c == 4'hF) return 1;
    if (c == 4'hE && inside_rgn(14, a)) return 1;
    if (c == 4'hE || c == 4'h0) begin
      for (int i = 0; i < 15; i++) if (inside_rgn(i, a)) return 0;
      return 1;
    end
    return inside_rgn(int'(c) - 1, a);
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [3:0] c, logic [31:0] a, logic [31:0] d, bit w,
                      bit cwe, logic [3:0] cc, logic [5:0] ca, logic [31:0] cd);
    bit viol, clr;
    bit n_irq; logic [3:0] n_vctx; logic [31:0] n_vaddr;
    req_valid = v; req_ctx = c; req_addr = a; req_wdata = d; req_write = w;
    cfg_we = cwe; cfg_ctx = cc; cfg_addr = ca; cfg_wdata = cd;
    viol = v && !permitted(c, a);
    clr  = cwe && cc == 4'hF && ca == 6'h3C;
    n_irq = m_irq; n_vctx = m_vctx; n_vaddr = m_vaddr;
    if (viol) begin
      n_irq = 1;
      if (!m_irq || clr) begin n_vctx = c; n_vaddr = a; end
    end else if (clr) n_irq = 0;
    @(posedge clk);
    e_valid = v; e_write = w;
    e_addr  = viol ? SCR : a;
    e_wdata = viol ? 32'h0 : d;
    m_irq = n_irq; m_vctx = n_vctx; m_vaddr = n_vaddr;
    if (cwe && cc == 4'hF && !clr && (ca >> 2) < 15) begin
      case (ca % 4)
        0: m_base[ca >> 2] = cd;
        1: m_mask[ca >> 2] = cd;
        2: m_vld[ca >> 2]  = cd[0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R6 out_valid", 32'(out_valid), 32'(e_valid));
    if (e_valid) begin
      chk(viol ? "R7 out_addr" : "out_addr", out_addr, e_addr);
      chk(viol ? "R7 out_wdata" : "out_wdata", out_wdata, e_wdata);
      chk("out_write", 32'(out_write), 32'(e_write));
    end
    chk("R8 viol_irq", 32'(viol_irq), 32'(m_irq));
    chk("R9 viol_ctx", 32'(viol_ctx), 32'(m_vctx));
    chk("R9 viol_addr", viol_addr, m_vaddr);
  endtask

  task automatic rq(logic [3:0] c, logic [31:0] a, bit w = 0, logic [31:0] d = 32'hA5A5_0001);
    step(1, c, a, d, w, 0, 0, 0, 0);
  endtask

  task automatic cf(logic [3:0] cc, logic [5:0] ca, logic [31:0] cd);
    step(0, 0, 0, 0, 0, 1, cc, ca, cd);
  endtask

  task automatic set_rgn(int r, logic [31:0] b, logic [31:0] m);
    cf(4'hF, 6'(4*r), b); cf(4'hF, 6'(4*r+1), m); cf(4'hF, 6'(4*r+2), 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 15; i++) begin m_base[i] = 0; m_mask[i] = 0; m_vld[i] = 0; end
    m_irq = 0; m_vctx = 0; m_vaddr = 0;
    repeat (3) @(negedge clk);
    cur = "R11";
    chk("R11 out_valid in reset", 32'(out_valid), 0);
    chk("R11 irq in reset", 32'(viol_irq), 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rq(4'h0, 32'h1000_0000);               // R11: no valid region, OS passes
    rq(4'h3, 32'h0000_0040);               // R11/R3: enclave with invalid region refused

    cur = "R8"; cf(4'hF, 6'h3C, 0);        // R8 clear

    cur = "R10";
    set_rgn(0, 32'h1000_0000, 32'hFFFF_0000);
    set_rgn(1, 32'h2000_0000, 32'hFFFF_0000);
    set_rgn(13, 32'h3000_0000, 32'hFFFF_F000);
    set_rgn(14, 32'h4000_0000, 32'hFFFF_0000);
    cf(4'h0, 6'd8, 32'h5000_0000); cf(4'h0, 6'd9, 32'hFFFF_0000); cf(4'h0, 6'd10, 1); // R10 foreign
    cf(4'hE, 6'd10, 1);
    rq(4'h0, 32'h5000_0010);               // R10: region 2 still invalid
    rq(4'h3, 32'h5000_0010);               // R10: enclave 3 still refused
    cf(4'hF, 6'h3C, 0);
    // R10: write and request in same cycle use old descriptor
    step(1, 4'h0, 32'h7000_0000, 32'h1, 1, 1, 4'hF, 6'd8, 32'h7000_0000);
    cf(4'hF, 6'd9, 32'hFF00_0000); cf(4'hF, 6'd10, 1);
    rq(4'h3, 32'h70AB_0000);

    cur = "R1";
    cf(4'hF, 6'd8, 32'h6000_00F0); cf(4'hF, 6'd9, 32'hF000_00F0);
    rq(4'h3, 32'h6123_45F7);
    rq(4'h3, 32'h6000_0007);
    rq(4'h1, 32'h1000_ABCD);
    rq(4'h1, 32'h1001_0000, 1, 32'hDEAD_BEEF);
    cf(4'hF, 6'h3C, 0);

    cur = "R2";
    rq(4'hF, 32'h1000_0000, 1, 32'h1234_5678);
    rq(4'hF, 32'h3000_0004);
    rq(4'hF, 32'h4000_0000);

    cur = "R3";
    rq(4'h2, 32'h2000_0100, 1, 32'h55);
    rq(4'h2, 32'h1000_0100, 1, 32'h66);
    rq(4'h5, 32'h0000_0000);
    cf(4'hF, 6'h3C, 0);

    cur = "R4";
    rq(4'h0, 32'h0000_1234, 1, 32'h77);
    rq(4'h0, 32'h1000_0004, 1, 32'h88);
    rq(4'h0, 32'h3000_0000);
    cf(4'hF, 6'h3C, 0);

    cur = "R5";
    rq(4'hE, 32'h4000_0010, 1, 32'h99);
    rq(4'hE, 32'h7F00_0000);
    rq(4'hE, 32'h1000_0000);
    rq(4'hE, 32'h3000_0008);

    cur = "R8";
    cf(4'h0, 6'h3C, 0);                    // foreign clear ignored
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);       // idle keeps state
    step(1, 4'h0, 32'h2000_0000, 0, 0, 1, 4'hF, 6'h3C, 0); // R9: clear+refusal same cycle
    cf(4'hF, 6'h3C, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);

    cur = "R6";
    for (int k = 0; k < 400; k++) begin
      logic [3:0]  c = 4'($urandom_range(0, 15));
      logic [31:0] a = {4'($urandom_range(0, 7)), 12'h000, 16'($urandom)};
      if (k % 37 == 0) cf(4'hF, 6'h3C, 0);
      else step($urandom_range(0, 3) != 0, c, a, $urandom, 1'($urandom), 0, 0, 0, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule